// File: doc/BRIEF.md
# PCI-to-PCI Bridge Configuration Header

This block holds the type-1 configuration header of a PCI-to-PCI bridge and is reached through a plain configuration access port. The port carries a byte offset, an access size of 1, 2 or 4 bytes, write data and separate read and write strobes. A read returns registered data and an error flag one clock after its strobe. A write lands on the edge that samples its strobe. A write of 1 or 2 bytes is merged into the addressed dword.

The identity dwords are fixed and ignore writes. The bus-number, I/O, memory and prefetchable window fields are writable storage and are also driven out as ports, so that routing and decode logic downstream can use them directly. The I/O base and limit bytes always report 32-bit I/O addressing. Offsets with no register behind them read as all ones and raise the error flag. A write of the secondary bus number also loads a separate local bus-number output. The local port uses that output as its own bus number.

Top module: `bridge_cfg_hdr`

## Requirements
- R1: Dword 0x00 reads {DEVICE_ID (default 0x7846) in bits 31:16, VENDOR_ID (default 0xC0DE) in bits 15:0}. Dword 0x08 reads 0x06040000, which is the bridge class code with zero interface and revision. Dword 0x0C reads 0x00010010, which is header type 0x01 and cache line size 0x10. Writes to these three dwords change nothing and do not raise the error flag.
- R2: After reset the following values hold. Status (0x04 bits 31:16) is 0x0010 and command is 0. The I/O base and I/O limit bytes are 0x01. Every other writable field is 0. Read data is 0 and the error flag is 0.
- R3: Read data and the error flag update on the clock edge that samples a strobe. They hold their value while no strobe is asserted.
- R4: A read of size 1 or 2 returns the addressed dword shifted right by 8×(offset & 3), masked to 8 or 16 bits and zero-extended.
- R5: A write of size 1 or 2 takes the low 8 or 16 bits of the write data and places them at byte lane (offset & 3). The other bytes of the dword keep their value. A size-4 write replaces the whole dword. The BARs at 0x10 and 0x14, and command and status at 0x04, are plain read/write storage.
- R6: Dword 0x1C packs {secondary status[31:16], I/O limit[15:8], I/O base[7:0]}. Every write forces bit 0 of both the I/O base byte and the I/O limit byte to 1.
- R7: Dword 0x18 packs, from the top byte down, {secondary latency timer, subordinate bus, secondary bus, primary bus}. Any write to it also loads the local bus-number output with the new secondary bus.
- R8: Dword 0x20 packs memory {limit[31:16], base[15:0]}, and dword 0x24 packs the prefetchable limit and base the same way. Dwords 0x28 and 0x2C are the full 32-bit prefetchable upper base and upper limit. Dword 0x30 packs I/O {upper limit[31:16], upper base[15:0]}. Each field appears on its own output port.
- R9: Dword 0x38 reads 0 with no error. Any other offset without a register reads 0xFFFFFFFF and raises the error flag. The unmapped offsets include 0x34, 0x3C and everything from 0x40 up. Writes to those offsets change no state and raise no error.
- R10: An access size other than 1, 2 or 4 raises the error flag. Such a read returns 0xFFFFFFFF, and such a write changes no state.
- R11: When read and write strobes are asserted together, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_off | input | OFF_W | Byte offset of the access |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_rd | input | 1 | Read strobe, one cycle per access |
| acc_wr | input | 1 | Write strobe, one cycle per access |
| acc_wdata | input | 32 | Write data, right-aligned |
| acc_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | Registered error flag of the last access |
| bus_pri | output | 8 | Primary bus number |
| bus_sec | output | 8 | Secondary bus number |
| bus_sub | output | 8 | Subordinate bus number |
| bus_local | output | 8 | Local bus number, loaded by bus-number writes |
| io_base | output | 8 | I/O base byte |
| io_limit | output | 8 | I/O limit byte |
| io_base_up | output | 16 | I/O upper base |
| io_limit_up | output | 16 | I/O upper limit |
| mem_base | output | 16 | Memory window base |
| mem_limit | output | 16 | Memory window limit |
| pf_base | output | 16 | Prefetchable window base |
| pf_limit | output | 16 | Prefetchable window limit |
| pf_base_up | output | 32 | Prefetchable upper base |
| pf_limit_up | output | 32 | Prefetchable upper limit |

## Verification
The bench sends byte and halfword writes with junk in the unused data bits, then reads the dword back. A merge that fails to mask the data or picks the wrong lane corrupts neighbouring bytes. It reads halfwords at lane 3, where a wrong shift or mask returns more than one byte. It writes an offset that differs from a BAR only in the upper offset bits, to catch a decode that ignores those bits and aliases the write onto the BAR. It also writes values with bit 0 clear to the I/O dword, uses an illegal size, and raises both strobes at once. A design that does not force the I/O type bit, accepts a bad-size write, or lets the write through alongside the read fails the read-back.

// File: rtl/bridge_cfg_hdr.sv
module bridge_cfg_hdr #(
  parameter int          OFF_W     = 8,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h7846
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [2:0]       acc_size,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  output logic             acc_err,
  output logic [7:0]       bus_pri,
  output logic [7:0]       bus_sec,
  output logic [7:0]       bus_sub,
  output logic [7:0]       bus_local,
  output logic [7:0]       io_base,
  output logic [7:0]       io_limit,
  output logic [15:0]      io_base_up,
  output logic [15:0]      io_limit_up,
  output logic [15:0]      mem_base,
  output logic [15:0]      mem_limit,
  output logic [15:0]      pf_base,
  output logic [15:0]      pf_limit,
  output logic [31:0]      pf_base_up,
  output logic [31:0]      pf_limit_up
);
  localparam logic [15:0] CLASS_BRIDGE = 16'h0604;
  localparam logic [7:0]  HDR_BRIDGE   = 8'h01;
  localparam logic [7:0]  CLS_RESET    = 8'h10;
  localparam logic [7:0]  IO_TYPE32    = 8'h01;
  localparam logic [15:0] STS_RESET    = 16'h0010;

  localparam logic [OFF_W-1:0] A_ID   = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] A_CMD  = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] A_CLS  = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] A_HDR  = OFF_W'(8'h0C);
  localparam logic [OFF_W-1:0] A_BAR0 = OFF_W'(8'h10);
  localparam logic [OFF_W-1:0] A_BAR1 = OFF_W'(8'h14);
  localparam logic [OFF_W-1:0] A_BUS  = OFF_W'(8'h18);
  localparam logic [OFF_W-1:0] A_IO   = OFF_W'(8'h1C);
  localparam logic [OFF_W-1:0] A_MEM  = OFF_W'(8'h20);
  localparam logic [OFF_W-1:0] A_PF   = OFF_W'(8'h24);
  localparam logic [OFF_W-1:0] A_PFBU = OFF_W'(8'h28);
  localparam logic [OFF_W-1:0] A_PFLU = OFF_W'(8'h2C);
  localparam logic [OFF_W-1:0] A_IOU  = OFF_W'(8'h30);
  localparam logic [OFF_W-1:0] A_ROM  = OFF_W'(8'h38);

  logic [15:0] cmd_q, sts_q, ssts_q;
  logic [31:0] bar0_q, bar1_q;
  logic [7:0]  slat_q;

  logic [OFF_W-1:0] dw_off;
  logic [4:0]       sh;
  logic             size_ok, hit, do_wr;
  logic [31:0]      cur, szmask, lanemask, merged, rsh, rd_val;

  assign dw_off   = {acc_off[OFF_W-1:2], 2'b00};
  assign sh       = {acc_off[1:0], 3'b000};
  assign size_ok  = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);
  assign do_wr    = acc_wr && !acc_rd && size_ok;

  always_comb begin
    hit = 1'b1;
    cur = 32'hFFFF_FFFF;
    case (dw_off)
      A_ID:   cur = {DEVICE_ID, VENDOR_ID};
      A_CMD:  cur = {sts_q, cmd_q};
      A_CLS:  cur = {CLASS_BRIDGE, 16'h0000};
      A_HDR:  cur = {8'h00, HDR_BRIDGE, 8'h00, CLS_RESET};
      A_BAR0: cur = bar0_q;
      A_BAR1: cur = bar1_q;
      A_BUS:  cur = {slat_q, bus_sub, bus_sec, bus_pri};
      A_IO:   cur = {ssts_q, io_limit, io_base};
      A_MEM:  cur = {mem_limit, mem_base};
      A_PF:   cur = {pf_limit, pf_base};
      A_PFBU: cur = pf_base_up;
      A_PFLU: cur = pf_limit_up;
      A_IOU:  cur = {io_limit_up, io_base_up};
      A_ROM:  cur = 32'h0000_0000;
      default: hit = 1'b0;
    endcase
  end

  assign szmask   = (acc_size == 3'd1) ? 32'h0000_00FF :
                    (acc_size == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign lanemask = szmask << sh;
  assign merged   = (cur & ~lanemask) | ((acc_wdata & szmask) << sh);

  assign rsh    = cur >> sh;
  assign rd_val = (!size_ok || !hit) ? 32'hFFFF_FFFF :
                  (acc_size == 3'd1) ? {24'h0, rsh[7:0]} :
                  (acc_size == 3'd2) ? {16'h0, rsh[15:0]} : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rdata <= 32'h0;
      acc_err   <= 1'b0;
    end else if (acc_rd) begin
      acc_rdata <= rd_val;
      acc_err   <= !size_ok || !hit;
    end else if (acc_wr) begin
      acc_err   <= !size_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= 16'h0;
      sts_q       <= STS_RESET;
      bar0_q      <= 32'h0;
      bar1_q      <= 32'h0;
      bus_pri     <= 8'h0;
      bus_sec     <= 8'h0;
      bus_sub     <= 8'h0;
      slat_q      <= 8'h0;
      bus_local   <= 8'h0;
      io_base     <= IO_TYPE32;
      io_limit    <= IO_TYPE32;
      ssts_q      <= 16'h0;
      mem_base    <= 16'h0;
      mem_limit   <= 16'h0;
      pf_base     <= 16'h0;
      pf_limit    <= 16'h0;
      pf_base_up  <= 32'h0;
      pf_limit_up <= 32'h0;
      io_base_up  <= 16'h0;
      io_limit_up <= 16'h0;
    end else if (do_wr) begin
      case (dw_off)
        A_CMD: begin
          cmd_q <= merged[15:0];
          sts_q <= merged[31:16];
        end
        A_BAR0: bar0_q <= merged;
        A_BAR1: bar1_q <= merged;
        A_BUS: begin
          bus_pri   <= merged[7:0];
          bus_sec   <= merged[15:8];
          bus_sub   <= merged[23:16];
          slat_q    <= merged[31:24];
          bus_local <= merged[15:8];
        end
        A_IO: begin
          io_base  <= merged[7:0] | IO_TYPE32;
          io_limit <= merged[15:8] | IO_TYPE32;
          ssts_q   <= merged[31:16];
        end
        A_MEM: begin
          mem_base  <= merged[15:0];
          mem_limit <= merged[31:16];
        end
        A_PF: begin
          pf_base  <= merged[15:0];
          pf_limit <= merged[31:16];
        end
        A_PFBU: pf_base_up  <= merged;
        A_PFLU: pf_limit_up <= merged;
        A_IOU: begin
          io_base_up  <= merged[15:0];
          io_limit_up <= merged[31:16];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bridge_cfg_hdr_chk.sv
module bridge_cfg_hdr_chk #(
  parameter int          OFF_W     = 8,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h7846
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFF_W-1:0] acc_off,
  input logic [2:0]       acc_size,
  input logic             acc_rd,
  input logic             acc_wr,
  input logic [31:0]      acc_wdata,
  input logic [31:0]      acc_rdata,
  input logic             acc_err,
  input logic [7:0]       bus_sec,
  input logic [7:0]       bus_local,
  input logic [7:0]       io_base,
  input logic [7:0]       io_limit,
  input logic [15:0]      mem_base,
  input logic [15:0]      mem_limit
);
  logic legal;
  assign legal = (acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4);

  AST_ID_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && acc_off == OFF_W'(8'h00) && acc_size == 3'd4 |=> acc_rdata == {DEVICE_ID, VENDOR_ID} && !acc_err); // R1

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd && !acc_wr |=> $stable(acc_rdata) && $stable(acc_err)); // R3

  AST_IO_TYPE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !acc_rd && acc_off == OFF_W'(8'h1C) && acc_size == 3'd4
    |=> io_base == {$past(acc_wdata[7:1]), 1'b1} && io_limit == {$past(acc_wdata[15:9]), 1'b1}); // R6

  AST_LOCAL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && !acc_rd && acc_off == OFF_W'(8'h19) && acc_size == 3'd1
    |=> bus_sec == $past(acc_wdata[7:0]) && bus_local == $past(acc_wdata[7:0])); // R7

  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(mem_base) && $stable(mem_limit)); // R8

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && legal && acc_off >= OFF_W'(8'h40) |=> acc_rdata == 32'hFFFF_FFFF && acc_err); // R9

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) && !legal |=> acc_err); // R10
endmodule

bind bridge_cfg_hdr bridge_cfg_hdr_chk #(.OFF_W(OFF_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .acc_size(acc_size), .acc_rd(acc_rd),
  .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
  .bus_sec(bus_sec), .bus_local(bus_local), .io_base(io_base), .io_limit(io_limit),
  .mem_base(mem_base), .mem_limit(mem_limit)
);

// File: tb/sim_bridge_cfg_hdr.sv
`timescale 1ns/1ps
module sim_bridge_cfg_hdr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  acc_off = '0;
  logic [2:0]  acc_size = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic [7:0]  bus_pri, bus_sec, bus_sub, bus_local, io_base, io_limit;
  logic [15:0] io_base_up, io_limit_up, mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_up, pf_limit_up;

  always #2.5 clk = ~clk;

  bridge_cfg_hdr u0 (
    .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .acc_size(acc_size), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .bus_pri(bus_pri), .bus_sec(bus_sec), .bus_sub(bus_sub), .bus_local(bus_local),
    .io_base(io_base), .io_limit(io_limit), .io_base_up(io_base_up), .io_limit_up(io_limit_up),
    .mem_base(mem_base), .mem_limit(mem_limit), .pf_base(pf_base), .pf_limit(pf_limit),
    .pf_base_up(pf_base_up), .pf_limit_up(pf_limit_up)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  bit issued = 1'b0;
  logic [31:0] q_exp[$];
  bit          q_err[$];
  bit          q_dchk[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] off, input logic [2:0] sz, input bit rd, input bit wr,
                        input logic [31:0] d, input logic [31:0] exp, input bit eerr, input string tag);
    @(negedge clk);
    acc_off = off; acc_size = sz; acc_rd = rd; acc_wr = wr; acc_wdata = d;
    q_exp.push_back(exp); q_err.push_back(eerr); q_dchk.push_back(rd); q_tag.push_back(tag);
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] exp,
                    input bit eerr, input string tag);
    access(off, sz, 1'b1, 1'b0, 32'h0, exp, eerr, tag);
  endtask

  task automatic wr(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] d,
                    input bit eerr, input string tag);
    access(off, sz, 1'b0, 1'b1, d, 32'h0, eerr, tag);
  endtask

  always @(posedge clk) issued <= rst_n && (acc_rd || acc_wr);

  always @(negedge clk) begin
    if (issued && q_exp.size() > 0) begin
      logic [31:0] e;
      bit ee, dc;
      string t;
      e = q_exp.pop_front(); ee = q_err.pop_front(); dc = q_dchk.pop_front(); t = q_tag.pop_front();
      if (dc) check({t, " data"}, acc_rdata, e);
      check({t, " err"}, {31'h0, acc_err}, {31'h0, ee});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R3 act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 rdata reset", acc_rdata, 32'h0);
    check("R2 err reset", {31'h0, acc_err}, 32'h0);
    check("R2 io_base reset", {24'h0, io_base}, 32'h01);
    check("R2 io_limit reset", {24'h0, io_limit}, 32'h01);
    check("R2 bus reset", {bus_pri, bus_sec, bus_sub, bus_local}, 32'h0);
    check("R2 mem reset", {mem_limit, mem_base}, 32'h0);

    rd(8'h00, 3'd4, 32'h7846_C0DE, 1'b0, "R1 id dword");
    rd(8'h08, 3'd4, 32'h0604_0000, 1'b0, "R1 class dword");
    rd(8'h0C, 3'd4, 32'h0001_0010, 1'b0, "R1 header dword");
    repeat (2) @(negedge clk);
    check("R3 rdata held", acc_rdata, 32'h0001_0010);
    check("R3 err held", {31'h0, acc_err}, 32'h0);
    rd(8'h04, 3'd4, 32'h0010_0000, 1'b0, "R2 cmd/status reset");
    rd(8'h1C, 3'd4, 32'h0000_0101, 1'b0, "R2 io dword reset");
    rd(8'h10, 3'd4, 32'h0, 1'b0, "R2 bar0 reset");

    rd(8'h02, 3'd2, 32'h0000_7846, 1'b0, "R4 halfword lane2");
    rd(8'h03, 3'd1, 32'h0000_0078, 1'b0, "R4 byte lane3");
    rd(8'h01, 3'd1, 32'h0000_00C0, 1'b0, "R4 byte lane1");
    rd(8'h03, 3'd2, 32'h0000_0078, 1'b0, "R4 halfword lane3");

    wr(8'h00, 3'd4, 32'hFFFF_FFFF, 1'b0, "R1 write id");
    wr(8'h0C, 3'd1, 32'h0000_0055, 1'b0, "R1 write header");
    rd(8'h00, 3'd4, 32'h7846_C0DE, 1'b0, "R1 id unchanged");
    rd(8'h0C, 3'd4, 32'h0001_0010, 1'b0, "R1 header unchanged");

    wr(8'h10, 3'd4, 32'h1234_5678, 1'b0, "R5 bar0 full");
    rd(8'h10, 3'd4, 32'h1234_5678, 1'b0, "R5 bar0 readback");
    wr(8'h11, 3'd1, 32'hFFFF_FFAB, 1'b0, "R5 byte merge");
    rd(8'h10, 3'd4, 32'h1234_AB78, 1'b0, "R5 byte merge readback");
    wr(8'h12, 3'd2, 32'h9999_CAFE, 1'b0, "R5 half merge");
    rd(8'h10, 3'd4, 32'hCAFE_AB78, 1'b0, "R5 half merge readback");
    rd(8'h13, 3'd2, 32'h0000_00CA, 1'b0, "R4 half lane3 bar");
    wr(8'h14, 3'd4, 32'hA5A5_0F0F, 1'b0, "R5 bar1");
    rd(8'h14, 3'd4, 32'hA5A5_0F0F, 1'b0, "R5 bar1 readback");
    wr(8'h06, 3'd2, 32'h0000_FFFF, 1'b0, "R5 status write");
    wr(8'h04, 3'd1, 32'h0000_0007, 1'b0, "R5 command write");
    rd(8'h04, 3'd4, 32'hFFFF_0007, 1'b0, "R5 cmd/status readback");

    wr(8'h18, 3'd4, 32'h4030_2010, 1'b0, "R7 bus write");
    check("R7 bus_pri", {24'h0, bus_pri}, 32'h10);
    check("R7 bus_sec", {24'h0, bus_sec}, 32'h20);
    check("R7 bus_sub", {24'h0, bus_sub}, 32'h30);
    check("R7 bus_local", {24'h0, bus_local}, 32'h20);
    rd(8'h18, 3'd4, 32'h4030_2010, 1'b0, "R7 bus readback");
    wr(8'h19, 3'd1, 32'h0000_0055, 1'b0, "R7 sec byte");
    check("R7 bus_sec byte", {24'h0, bus_sec}, 32'h55);
    check("R7 bus_local byte", {24'h0, bus_local}, 32'h55);
    rd(8'h18, 3'd4, 32'h4030_5510, 1'b0, "R7 byte merge readback");

    wr(8'h1C, 3'd4, 32'h1234_F0E0, 1'b0, "R6 io write");
    check("R6 io_base", {24'h0, io_base}, 32'hE1);
    check("R6 io_limit", {24'h0, io_limit}, 32'hF1);
    rd(8'h1C, 3'd4, 32'h1234_F1E1, 1'b0, "R6 io readback");
    wr(8'h1D, 3'd1, 32'h0000_0080, 1'b0, "R6 io limit byte");
    rd(8'h1C, 3'd4, 32'h1234_81E1, 1'b0, "R6 io byte readback");

    wr(8'h20, 3'd4, 32'hABC0_1230, 1'b0, "R8 mem write");
    check("R8 mem_base", {16'h0, mem_base}, 32'h1230);
    check("R8 mem_limit", {16'h0, mem_limit}, 32'hABC0);
    wr(8'h26, 3'd2, 32'h0000_7770, 1'b0, "R8 pf limit half");
    check("R8 pf_limit", {16'h0, pf_limit}, 32'h7770);
    check("R8 pf_base", {16'h0, pf_base}, 32'h0);
    wr(8'h28, 3'd4, 32'hDEAD_BEEF, 1'b0, "R8 pf upper base");
    wr(8'h2C, 3'd4, 32'h0123_4567, 1'b0, "R8 pf upper limit");
    check("R8 pf_base_up", pf_base_up, 32'hDEAD_BEEF);
    check("R8 pf_limit_up", pf_limit_up, 32'h0123_4567);
    wr(8'h30, 3'd4, 32'h0002_0001, 1'b0, "R8 io upper");
    check("R8 io_base_up", {16'h0, io_base_up}, 32'h0001);
    check("R8 io_limit_up", {16'h0, io_limit_up}, 32'h0002);
    rd(8'h24, 3'd4, 32'h7770_0000, 1'b0, "R8 pf readback");

    rd(8'h38, 3'd4, 32'h0, 1'b0, "R9 rom reads zero");
    rd(8'h34, 3'd4, 32'hFFFF_FFFF, 1'b1, "R9 unmapped 0x34");
    rd(8'h3C, 3'd1, 32'hFFFF_FFFF, 1'b1, "R9 unmapped 0x3C byte");
    rd(8'h40, 3'd4, 32'hFFFF_FFFF, 1'b1, "R9 unmapped 0x40");
    wr(8'h50, 3'd4, 32'h0, 1'b0, "R9 unmapped write");
    wr(8'h34, 3'd4, 32'h0, 1'b0, "R9 unmapped write 0x34");
    rd(8'h10, 3'd4, 32'hCAFE_AB78, 1'b0, "R9 no alias onto bar0");
    rd(8'h34, 3'd4, 32'hFFFF_FFFF, 1'b1, "R9 0x34 still unmapped");

    rd(8'h00, 3'd3, 32'hFFFF_FFFF, 1'b1, "R10 bad size read");
    rd(8'h00, 3'd0, 32'hFFFF_FFFF, 1'b1, "R10 zero size read");
    wr(8'h10, 3'd3, 32'h0, 1'b1, "R10 bad size write");
    rd(8'h10, 3'd4, 32'hCAFE_AB78, 1'b0, "R10 bar0 after bad write");

    access(8'h10, 3'd4, 1'b1, 1'b1, 32'h0, 32'hCAFE_AB78, 1'b0, "R11 both strobes");
    rd(8'h10, 3'd4, 32'hCAFE_AB78, 1'b0, "R11 write dropped");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule